// File: doc/BRIEF.md
# Clock Loss Supervisor

This block supervises a PLL-based clock generator. It watches two status inputs, reference present and PLL locked, and decides which clock source the chip should run from. When one of them disappears it either falls back to a safe mode or asks for a chip reset. Which of the two it does depends on a loss-of-clock reset enable.

A lost reference sends the generator into self-clocked operation, where the PLL runs without a reference. A lost lock sends it into reference operation, where the reference clock is used directly. The block also applies a per-stop-mode policy that decides whether the PLL and the oscillator stay powered during a low-power stop. Losses that the policy itself causes during stop are hidden, and the status reads reflect them until the signal is back after wake-up.

Sticky loss flags are cleared by a write-one-to-clear strobe and are wiped by a loss-triggered reset. A separate reset-cause flag survives that reset, so software can tell why the chip was reset.

Top module: `clk_loss_sup`

## Requirements
- R1: While `rst` is high the mode reads 0 (reset) and `rst_req_o` is 1. After release, mode goes to 1 (normal) once both synchronized inputs are high, for source straps 00 (crystal), 01 (external reference) or 10 (1:1). Strap 11 (external clock) goes to mode 4 with `rst_req_o` 0.
- R2: Each of `ref_ok_i` and `lock_i` passes through two flops. A loss is declared only after the synchronized input has been low for `loss_limit_i` consecutive cycles. A shorter dropout has no effect. With a limit of 4, a drop driven just after a falling edge changes the mode at the 7th rising edge.
- R3: In normal mode with the reset enable at 0, a declared reference loss moves the mode to 3 (self-clocked) and sets `loc_sts_o`.
- R4: In normal mode with the reset enable at 0, a declared lock loss alone moves the mode to 2 (reference) and drops `lock_sts_o` to 0.
- R5: With `loc_rst_en_i` at 1, a declared loss in normal mode moves the mode to 0 and raises `rst_req_o` and `loc_cause_o`, while `loc_sts_o` reads 0. Mode 0 is left only when reference and lock are both present.
- R6: In external-clock mode (4), losses are ignored whatever the reset enable: the mode stays 4, `rst_req_o` stays 0 and the flags do not change.
- R7: During stop, `pll_en_o` is 1 only for `stop_cfg_i` 00 or 01. With the crystal strap, `osc_en_o` is 1 for every `stop_cfg_i` except 11. Outside stop, `pll_en_o` = (mode != 4) and `osc_en_o` = (strap == 00). With strap 01 or 10, `osc_en_o` is always 0.
- R8: A lock drop during stop with the PLL powered down, or a reference drop with the oscillator powered down, changes no mode. In that case `lock_sts_o` reads 0, or `loc_sts_o` reads 1, until the signal is back after stop exit. After that the read returns its value from before stop.
- R9: With strap 01 or 10, a reference drop during stop counts as a loss even for `stop_cfg_i` 11.
- R10: `status_w1c_i` bit 0 clears the loss-of-clock flag, bit 1 clears the loss-of-lock flag and bit 2 clears `loc_cause_o`. Bit 2 is ignored while `rst_req_o` is 1. Without a strobe, each flag holds its value.
- R11: If a reference loss and a lock loss are declared in the same cycle, the reference loss wins and the mode goes to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_ok_i | input | 1 | Reference clock present (asynchronous) |
| lock_i | input | 1 | PLL locked (asynchronous) |
| clk_src_i | input | 2 | Source strap: 00 crystal, 01 external reference, 10 1:1, 11 external clock |
| stop_req_i | input | 1 | Chip is in stop |
| stop_cfg_i | input | 2 | Stop power policy field |
| loc_rst_en_i | input | 1 | Request reset on clock loss instead of falling back |
| loss_limit_i | input | CNT_W | Consecutive low cycles before a loss is declared |
| status_w1c_i | input | 3 | Write-one-to-clear strobes: bit 0 loss-of-clock flag, bit 1 loss-of-lock flag, bit 2 reset cause |
| pll_en_o | output | 1 | PLL power enable |
| osc_en_o | output | 1 | Oscillator power enable |
| mode_o | output | 3 | 0 reset, 1 normal, 2 reference, 3 self-clocked, 4 external clock |
| rst_req_o | output | 1 | Chip reset request |
| loc_sts_o | output | 1 | Loss-of-clock status (1 = loss recorded) |
| lock_sts_o | output | 1 | Lock status (0 = loss recorded or relock pending) |
| loc_cause_o | output | 1 | Last reset was caused by a clock loss |

## Verification
Dropouts shorter and longer than the loss limit are applied, and the mode is sampled at the exact edge where it must change. This pins down the synchronizer and filter latency. Reference-only, lock-only and simultaneous drops tell the two fallback modes and their priority apart, and repeating them with the reset enable set separates fallback from reset. The same drops are then made during stop under each power policy and with each source strap. This shows whether a loss is caused by the policy itself and so hidden, or is a real loss.

// File: rtl/clksup_pkg.sv
package clksup_pkg;

    typedef enum logic [2:0] {
        M_RST = 3'd0,
        M_NRM = 3'd1,
        M_REF = 3'd2,
        M_SCM = 3'd3,
        M_EXT = 3'd4
    } mode_e;

    typedef enum logic [1:0] {
        SRC_XTAL = 2'b00,
        SRC_EREF = 2'b01,
        SRC_ONE  = 2'b10,
        SRC_EXT  = 2'b11
    } src_e;

    localparam int W1C_W     = 3;
    localparam int W1C_LOC   = 0;
    localparam int W1C_LOL   = 1;
    localparam int W1C_CAUSE = 2;
    localparam int N_MON     = 2;
    localparam int MON_REF   = 0;
    localparam int MON_LOCK  = 1;

    typedef struct packed {
        logic ref_ev;
        logic lock_ev;
    } loss_t;

    // PLL kept powered in stop only for the two lightest policies
    function automatic logic pll_kept(input logic [1:0] cfg);
        return !cfg[1];
    endfunction

    // oscillator dropped only by the deepest policy
    function automatic logic osc_kept(input logic [1:0] cfg);
        return cfg != 2'b11;
    endfunction

endpackage

// File: rtl/clksup_filter.sv
module clksup_filter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             raw_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             sync_o,
    output logic             lost_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             meta_q;
    logic             sync_q;
    logic [CNT_W-1:0] low_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q    <= 1'b0;
            sync_q    <= 1'b0;
            low_cnt_q <= '0;
        end else begin
            meta_q <= raw_i;
            sync_q <= meta_q;
            if (sync_q)
                low_cnt_q <= '0;
            else if (low_cnt_q != CNT_MAX)
                low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    assign sync_o = sync_q;
    assign lost_o = !sync_q && (low_cnt_q >= limit_i);

    // R2: a loss can only appear after the synchronized input was already low
    a_r2_loss_after_low: assert property (@(posedge clk) disable iff (rst || limit_i == '0)
        $rose(lost_o) |-> $past(!sync_o));

endmodule

// File: rtl/clksup_fsm.sv
module clksup_fsm
    import clksup_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  src_e  src_i,
    input  logic  ref_sync_i,
    input  logic  lock_sync_i,
    input  loss_t loss_i,
    input  logic  loc_rst_en_i,
    output mode_e mode_o,
    output logic  fire_o
);
    mode_e st_q, st_d;
    logic  fire_d;

    always_comb begin
        st_d   = st_q;
        fire_d = 1'b0;
        case (st_q)
            M_RST: begin
                if (src_i == SRC_EXT)
                    st_d = M_EXT;
                else if (ref_sync_i && lock_sync_i)
                    st_d = M_NRM;
            end
            M_NRM: begin
                if (loss_i.ref_ev || loss_i.lock_ev) begin
                    if (loc_rst_en_i) begin
                        st_d   = M_RST;
                        fire_d = 1'b1;
                    end else if (loss_i.ref_ev) begin
                        st_d = M_SCM;
                    end else begin
                        st_d = M_REF;
                    end
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= M_RST;
        else     st_q <= st_d;
    end

    assign mode_o = st_q;
    assign fire_o = fire_d;

    // R5: a loss-triggered reset lands in the reset mode next cycle
    a_r5_fire_to_reset: assert property (@(posedge clk) disable iff (rst)
        fire_o |=> (mode_o == M_RST));

    // R1: reset is held while a PLL source lacks reference or lock
    a_r1_hold_reset: assert property (@(posedge clk) disable iff (rst)
        (mode_o == M_RST && src_i != SRC_EXT && !(ref_sync_i && lock_sync_i))
        |=> (mode_o == M_RST));

    // R6: external-clock mode is never left
    a_r6_ext_kept: assert property (@(posedge clk) disable iff (rst)
        (mode_o == M_EXT) |=> (mode_o == M_EXT));

endmodule

// File: rtl/clksup_status.sv
module clksup_status
    import clksup_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  mode_e            mode_i,
    input  src_e             src_i,
    input  logic             stop_i,
    input  logic [1:0]       cfg_i,
    input  logic             ref_sync_i,
    input  logic             lock_sync_i,
    input  logic             ref_lost_i,
    input  logic             lock_lost_i,
    input  logic             fire_i,
    input  logic [W1C_W-1:0] w1c_i,
    output loss_t            loss_o,
    output logic             loc_sts_o,
    output logic             lock_sts_o,
    output logic             cause_o
);
    logic wake_ref_q, wake_lock_q;
    logic loc_q, lol_q, cause_q;
    logic osc_off, pll_off, watching;

    // only the crystal source powers the oscillator, so only it can hide a reference drop
    assign osc_off  = stop_i && (src_i == SRC_XTAL) && !osc_kept(cfg_i);
    assign pll_off  = stop_i && !pll_kept(cfg_i);
    assign watching = (mode_i == M_NRM) || (mode_i == M_REF) || (mode_i == M_SCM);

    assign loss_o.ref_ev  = watching && ref_lost_i  && !(wake_ref_q  || osc_off);
    assign loss_o.lock_ev = watching && lock_lost_i && !(wake_lock_q || pll_off);

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_ref_q  <= 1'b0;
            wake_lock_q <= 1'b0;
            loc_q       <= 1'b0;
            lol_q       <= 1'b0;
            cause_q     <= 1'b0;
        end else begin
            if (osc_off)                  wake_ref_q <= 1'b1;
            else if (!stop_i && ref_sync_i) wake_ref_q <= 1'b0;

            if (pll_off)                   wake_lock_q <= 1'b1;
            else if (!stop_i && lock_sync_i) wake_lock_q <= 1'b0;

            if (fire_i || mode_i == M_RST) begin
                loc_q <= 1'b0;
                lol_q <= 1'b0;
            end else begin
                if (loss_o.ref_ev)          loc_q <= 1'b1;
                else if (w1c_i[W1C_LOC])    loc_q <= 1'b0;
                if (loss_o.lock_ev)         lol_q <= 1'b1;
                else if (w1c_i[W1C_LOL])    lol_q <= 1'b0;
            end

            if (fire_i)
                cause_q <= 1'b1;
            else if (w1c_i[W1C_CAUSE] && mode_i != M_RST)
                cause_q <= 1'b0;
        end
    end

    assign loc_sts_o  = loc_q || wake_ref_q;
    assign lock_sts_o = !lol_q && !wake_lock_q;
    assign cause_o    = cause_q;

    // R10: the reset cause survives any strobe while reset is pending
    a_r10_cause_kept: assert property (@(posedge clk) disable iff (rst)
        (mode_i == M_RST && cause_o) |=> cause_o);

    // R8: a stop policy that drops the PLL hides the lock status
    a_r8_lock_hidden: assert property (@(posedge clk) disable iff (rst)
        pll_off |=> !lock_sts_o);

    // R5: a loss-triggered reset always records its cause
    a_r5_cause_set: assert property (@(posedge clk) disable iff (rst)
        fire_i |=> cause_o);

endmodule

// File: rtl/clk_loss_sup.sv
module clk_loss_sup
    import clksup_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_ok_i,
    input  logic             lock_i,
    input  logic [1:0]       clk_src_i,
    input  logic             stop_req_i,
    input  logic [1:0]       stop_cfg_i,
    input  logic             loc_rst_en_i,
    input  logic [CNT_W-1:0] loss_limit_i,
    input  logic [2:0]       status_w1c_i,
    output logic             pll_en_o,
    output logic             osc_en_o,
    output logic [2:0]       mode_o,
    output logic             rst_req_o,
    output logic             loc_sts_o,
    output logic             lock_sts_o,
    output logic             loc_cause_o
);
    src_e             src;
    mode_e            mode;
    loss_t            loss;
    logic             fire;
    logic [N_MON-1:0] raw_v, sync_v, lost_v;

    assign src = src_e'(clk_src_i);
    assign raw_v[MON_REF]  = ref_ok_i;
    assign raw_v[MON_LOCK] = lock_i;

    for (genvar g = 0; g < N_MON; g++) begin : g_mon
        clksup_filter #(.CNT_W(CNT_W)) u_filter (
            .clk     (clk),
            .rst     (rst),
            .raw_i   (raw_v[g]),
            .limit_i (loss_limit_i),
            .sync_o  (sync_v[g]),
            .lost_o  (lost_v[g])
        );
    end

    clksup_status u_status (
        .clk         (clk),
        .rst         (rst),
        .mode_i      (mode),
        .src_i       (src),
        .stop_i      (stop_req_i),
        .cfg_i       (stop_cfg_i),
        .ref_sync_i  (sync_v[MON_REF]),
        .lock_sync_i (sync_v[MON_LOCK]),
        .ref_lost_i  (lost_v[MON_REF]),
        .lock_lost_i (lost_v[MON_LOCK]),
        .fire_i      (fire),
        .w1c_i       (status_w1c_i),
        .loss_o      (loss),
        .loc_sts_o   (loc_sts_o),
        .lock_sts_o  (lock_sts_o),
        .cause_o     (loc_cause_o)
    );

    clksup_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .src_i        (src),
        .ref_sync_i   (sync_v[MON_REF]),
        .lock_sync_i  (sync_v[MON_LOCK]),
        .loss_i       (loss),
        .loc_rst_en_i (loc_rst_en_i),
        .mode_o       (mode),
        .fire_o       (fire)
    );

    assign pll_en_o  = (mode != M_EXT) && (!stop_req_i || pll_kept(stop_cfg_i));
    assign osc_en_o  = (src == SRC_XTAL) && (!stop_req_i || osc_kept(stop_cfg_i));
    assign mode_o    = mode;
    assign rst_req_o = (mode == M_RST);

    // R7: the deep stop policies power the PLL down
    a_r7_pll_down_in_stop: assert property (@(posedge clk) disable iff (rst)
        (stop_req_i && stop_cfg_i[1]) |-> !pll_en_o);

    // R3: self-clocked fallback holds until reset
    a_r3_scm_held: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'd3) |=> (mode_o == 3'd3));

    // R4: reference fallback holds until reset
    a_r4_ref_held: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'd2) |=> (mode_o == 3'd2));

endmodule

// File: tb/test_clk_loss_sup.sv
module test_clk_loss_sup;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;

    logic             clk = 1'b0;
    logic             rst;
    logic             ref_ok_i, lock_i, stop_req_i, loc_rst_en_i;
    logic [1:0]       clk_src_i, stop_cfg_i;
    logic [CNT_W-1:0] loss_limit_i;
    logic [2:0]       status_w1c_i;
    logic             pll_en_o, osc_en_o, rst_req_o, loc_sts_o, lock_sts_o, loc_cause_o;
    logic [2:0]       mode_o;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clk_loss_sup #(.CNT_W(CNT_W)) i_clk_loss_sup (
        .clk(clk), .rst(rst), .ref_ok_i(ref_ok_i), .lock_i(lock_i),
        .clk_src_i(clk_src_i), .stop_req_i(stop_req_i), .stop_cfg_i(stop_cfg_i),
        .loc_rst_en_i(loc_rst_en_i), .loss_limit_i(loss_limit_i),
        .status_w1c_i(status_w1c_i), .pll_en_o(pll_en_o), .osc_en_o(osc_en_o),
        .mode_o(mode_o), .rst_req_o(rst_req_o), .loc_sts_o(loc_sts_o),
        .lock_sts_o(lock_sts_o), .loc_cause_o(loc_cause_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_w1c(input logic [2:0] v);
        status_w1c_i = v;
        tick(1);
        status_w1c_i = 3'b000;
        tick(1);
    endtask

    task automatic do_reset(input logic [1:0] src);
        rst = 1'b1; ref_ok_i = 1'b1; lock_i = 1'b1; stop_req_i = 1'b0;
        stop_cfg_i = 2'b00; loc_rst_en_i = 1'b0; status_w1c_i = 3'b000;
        loss_limit_i = 8'd4; clk_src_i = src;
        tick(3);
        chk("R1 mode in reset", mode_o, 0);
        chk("R1 rst_req in reset", rst_req_o, 1);
        rst = 1'b0;
        tick(8);
    endtask

    task automatic t_reset_state;
        do_reset(2'b00);
        chk("R1 normal after start", mode_o, 1);
        chk("R1 rst_req released", rst_req_o, 0);
        chk("R7 pll_en normal", pll_en_o, 1);
        chk("R7 osc_en crystal", osc_en_o, 1);
        chk("R1 lock_sts clean", lock_sts_o, 1);
        chk("R1 loc_sts clean", loc_sts_o, 0);
        chk("R1 cause clean", loc_cause_o, 0);
        do_reset(2'b10);
        chk("R1 normal with 1:1 strap", mode_o, 1);
        chk("R7 osc_en off for 1:1", osc_en_o, 0);
        do_reset(2'b11);
        chk("R1 external strap mode", mode_o, 4);
        chk("R1 external strap no reset", rst_req_o, 0);
        chk("R7 pll_en off external", pll_en_o, 0);
        chk("R7 osc_en off external", osc_en_o, 0);
    endtask

    task automatic t_filter_and_ref_loss;
        do_reset(2'b00);
        ref_ok_i = 1'b0; tick(2); ref_ok_i = 1'b1;
        tick(10);
        chk("R2 short dropout ignored mode", mode_o, 1);
        chk("R2 short dropout ignored flag", loc_sts_o, 0);
        ref_ok_i = 1'b0;
        tick(6);
        chk("R2 not yet declared at edge 6", mode_o, 1);
        tick(1);
        chk("R3 self-clocked at edge 7", mode_o, 3);
        chk("R3 loc_sts set", loc_sts_o, 1);
        chk("R3 pll stays on", pll_en_o, 1);
        ref_ok_i = 1'b1;
        tick(6);
        chk("R10 loc flag sticky", loc_sts_o, 1);
        pulse_w1c(3'b001);
        chk("R10 loc flag cleared", loc_sts_o, 0);
        chk("R3 mode held after clear", mode_o, 3);
    endtask

    task automatic t_lock_loss;
        do_reset(2'b00);
        lock_i = 1'b0;
        tick(12);
        chk("R4 reference mode", mode_o, 2);
        chk("R4 lock_sts low", lock_sts_o, 0);
        chk("R4 loc_sts untouched", loc_sts_o, 0);
        lock_i = 1'b1;
        tick(6);
        chk("R10 lol flag sticky", lock_sts_o, 0);
        pulse_w1c(3'b010);
        chk("R10 lol flag cleared", lock_sts_o, 1);
    endtask

    task automatic t_both_lost;
        do_reset(2'b00);
        ref_ok_i = 1'b0; lock_i = 1'b0;
        tick(12);
        chk("R11 reference loss wins", mode_o, 3);
    endtask

    task automatic t_loss_reset;
        do_reset(2'b00);
        loc_rst_en_i = 1'b1;
        ref_ok_i = 1'b0;
        tick(12);
        chk("R5 reset mode", mode_o, 0);
        chk("R5 reset request", rst_req_o, 1);
        chk("R5 cause set", loc_cause_o, 1);
        chk("R5 loc_sts wiped", loc_sts_o, 0);
        pulse_w1c(3'b100);
        chk("R10 cause clear ignored in reset", loc_cause_o, 1);
        tick(10);
        chk("R5 held without reference", mode_o, 0);
        ref_ok_i = 1'b1;
        tick(8);
        chk("R5 released to normal", mode_o, 1);
        chk("R5 request dropped", rst_req_o, 0);
        chk("R5 cause kept after reset", loc_cause_o, 1);
        pulse_w1c(3'b100);
        chk("R10 cause cleared", loc_cause_o, 0);
        lock_i = 1'b0;
        tick(12);
        chk("R5 lock loss resets", mode_o, 0);
        chk("R5 cause from lock loss", loc_cause_o, 1);
        lock_i = 1'b1;
        tick(8);
        chk("R5 lock back to normal", mode_o, 1);
    endtask

    task automatic t_ext_mode;
        do_reset(2'b11);
        loc_rst_en_i = 1'b1;
        ref_ok_i = 1'b0; lock_i = 1'b0;
        tick(12);
        chk("R6 external mode kept", mode_o, 4);
        chk("R6 no reset request", rst_req_o, 0);
        chk("R6 loc_sts untouched", loc_sts_o, 0);
        chk("R6 lock_sts untouched", lock_sts_o, 1);
        chk("R6 cause untouched", loc_cause_o, 0);
    endtask

    task automatic t_stop_policy;
        do_reset(2'b00);
        for (int c = 0; c < 4; c++) begin
            stop_req_i = 1'b1; stop_cfg_i = 2'(c);
            tick(2);
            chk("R7 pll_en in stop", pll_en_o, (c < 2) ? 1 : 0);
            chk("R7 osc_en in stop", osc_en_o, (c != 3) ? 1 : 0);
            stop_req_i = 1'b0;
            tick(4);
        end
        chk("R7 pll_en after stop", pll_en_o, 1);
        stop_req_i = 1'b1; stop_cfg_i = 2'b10;
        lock_i = 1'b0;
        tick(12);
        chk("R8 no fallback on hidden lock drop", mode_o, 1);
        chk("R8 lock_sts reads 0 in stop", lock_sts_o, 0);
        stop_req_i = 1'b0;
        tick(12);
        chk("R8 still normal before relock", mode_o, 1);
        chk("R8 lock_sts 0 until relock", lock_sts_o, 0);
        lock_i = 1'b1;
        tick(6);
        chk("R8 lock_sts restored", lock_sts_o, 1);
        stop_req_i = 1'b1; stop_cfg_i = 2'b11;
        ref_ok_i = 1'b0; lock_i = 1'b0;
        tick(12);
        chk("R8 no fallback on hidden ref drop", mode_o, 1);
        chk("R8 loc_sts reads 1 in stop", loc_sts_o, 1);
        chk("R7 osc off in deep stop", osc_en_o, 0);
        stop_req_i = 1'b0;
        tick(6);
        chk("R8 loc_sts 1 until ref back", loc_sts_o, 1);
        ref_ok_i = 1'b1; lock_i = 1'b1;
        tick(6);
        chk("R8 loc_sts restored", loc_sts_o, 0);
        chk("R8 lock_sts restored again", lock_sts_o, 1);
        chk("R8 mode normal after wake", mode_o, 1);
    endtask

    task automatic t_ext_ref_stop;
        do_reset(2'b01);
        chk("R7 osc_en off for external ref", osc_en_o, 0);
        stop_req_i = 1'b1; stop_cfg_i = 2'b11;
        tick(2);
        chk("R7 pll_en off deep stop", pll_en_o, 0);
        ref_ok_i = 1'b0;
        tick(12);
        chk("R9 ref drop in stop is a loss", mode_o, 3);
        chk("R9 loc_sts set", loc_sts_o, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_filter_and_ref_loss();
        t_lock_loss();
        t_both_lost();
        t_loss_reset();
        t_ext_mode();
        t_stop_policy();
        t_ext_ref_stop();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule